// File: doc/BRIEF.md
# SPI ADC Channel Sampling Sequencer

This block takes a single 12-bit sample from an external eight-input successive-approximation converter over a four-wire SPI link. A user asserts `start` with a 3-bit channel number while the block is idle. The block drops chip select and clocks out a fixed 24-bit command. That command selects single-ended conversion on the requested input. At the same time the block shifts in the 24 bits the converter returns. When the frame ends, the block releases chip select and pulses `done` for one cycle. The assembled 12-bit value appears on `result` in that same cycle and stays there until the next frame completes.

A runtime divider input sets the serial clock period in system clocks. Typical settings are 256 for a slow link and 64 for a fast one. The line idles low and uses mode 0: the master updates MOSI on the falling edge and samples MISO on the rising edge, most significant bit first. After each frame the block keeps chip select high for at least one full serial clock period before it accepts another request.

Top module: `spi_adc_seq`

## Requirements
- R1: The 24-bit command is sent MSB first with bit 23 leading. Bits 23..19 are zero, bit 18 is the start marker (1), bit 17 selects single-ended mode (1), and bits 16..14 hold the channel number, MSB first. Bits 13..0 are zero, so the last byte is an all-zero filler.
- R2: `result` is bits 11..0 of the 24 bits captured from MISO, where the first bit received is bit 23. That is the low nibble of the second received byte followed by the whole third byte. The first received byte and the upper nibble of the second byte are discarded.
- R3: `cs_n` goes low when a request is accepted and stays low across exactly 24 rising SCLK edges. It returns high in the same cycle in which `done` is pulsed.
- R4: SCLK idles low and rises only while `cs_n` is low. With an even `sclk_div` of at least 4, consecutive rising edges within a frame are exactly `sclk_div` system clocks apart.
- R5: MOSI changes only while SCLK is low, so it is stable across every rising edge and every high phase.
- R6: A `start` asserted while `busy` is high is ignored: the frame in progress keeps its original channel and no extra frame or `done` follows.
- R7: `done` is high for exactly one cycle per frame, and `result` changes only in a cycle in which `done` is high.
- R8: Between the end of one frame and the start of the next, `cs_n` stays high for at least `sclk_div` system clocks, even when `start` is held high.
- R9: After reset, `cs_n` is high and `sclk`, `busy` and `done` are low. Whenever `busy` is low, `cs_n` is high and `sclk` is low. `busy` rises when a request is accepted and stays high through the post-frame gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_div | input | DIV_W | Serial clock period in system clocks (even, at least 4) |
| start | input | 1 | Request a conversion; accepted only when idle |
| chan | input | 3 | Converter input to sample |
| busy | output | 1 | A frame or the post-frame gap is in progress |
| done | output | 1 | One-cycle pulse at frame end |
| result | output | 12 | Last assembled conversion value |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Returned data from the converter |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bound checker enforces the cycle-local rules on every cycle: idle line levels, SCLK rising only under chip select, MOSI holding still while SCLK is high, `done` lasting one cycle, chip select rising together with `done`, and `result` changing only in a `done` cycle. Other properties span a whole frame and only the bench scenarios can show them. These are the exact command bit pattern, the number of rising edges and their spacing, the reassembly of the returned bits, the length of the gap, and the fact that a request made mid-frame leaves the channel and the count of `done` pulses unchanged. The bench shows them by using a converter model with random filler in the discarded bits, several divider settings, and a `start` held high across back-to-back frames.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;
  localparam int CH_W    = 3;
  localparam int FRAME_W = 24;
  localparam int RES_W   = 12;
  localparam int BITS_W  = $clog2(FRAME_W + 1);
  localparam int LEAD_Z  = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_t;

  function automatic logic [FRAME_W-1:0] build_cmd(input logic [CH_W-1:0] ch);
    logic [FRAME_W-1:0] f;
    f = '0;
    f[FRAME_W-LEAD_Z-1] = 1'b1;
    f[FRAME_W-LEAD_Z-2] = 1'b1;
    f[FRAME_W-LEAD_Z-3 -: CH_W] = ch;
    return f;
  endfunction
endpackage

// File: rtl/spi_adc_clkgen.sv
module spi_adc_clkgen #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-2:0] half,
  output logic             tick
);
  logic [DIV_W-2:0] cnt_q, cnt_d;
  logic [DIV_W-2:0] last;

  assign last = half - 1'b1;
  assign tick = run && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_adc_shifter.sv
module spi_adc_shifter
  import spi_adc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               shift_en,
  input  logic               sample_en,
  input  logic               miso,
  output logic               mosi,
  output logic [FRAME_W-1:0] rx
);
  logic [FRAME_W-1:0] tx_q, tx_d, rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load)          tx_d = load_val;
    else if (shift_en) tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    if (sample_en)     rx_d = {rx_q[FRAME_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi = tx_q[FRAME_W-1];
  assign rx   = rx_q;
endmodule

// File: rtl/spi_adc_ctrl.sv
module spi_adc_ctrl
  import spi_adc_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [DIV_W-1:0] period,
  output logic             run_clk,
  output logic             load,
  output logic             shift_en,
  output logic             sample_en,
  output logic             finish,
  output logic             sclk,
  output logic             cs_n,
  output logic             busy,
  output logic             done
);
  seq_state_t        st_q, st_d;
  logic              sclk_q, sclk_d, cs_q, cs_d, done_q, done_d;
  logic [BITS_W-1:0] bits_q, bits_d;
  logic [DIV_W-1:0]  gap_q, gap_d;

  always_comb begin
    st_d      = st_q;
    sclk_d    = sclk_q;
    cs_d      = cs_q;
    bits_d    = bits_q;
    gap_d     = gap_q;
    done_d    = 1'b0;
    load      = 1'b0;
    shift_en  = 1'b0;
    sample_en = 1'b0;
    finish    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_XFER;
          cs_d   = 1'b0;
          bits_d = '0;
          load   = 1'b1;
        end
      end
      ST_XFER: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d    = 1'b1;
            sample_en = 1'b1;
            bits_d    = bits_q + 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (bits_q == BITS_W'(FRAME_W)) begin
              cs_d   = 1'b1;
              done_d = 1'b1;
              finish = 1'b1;
              gap_d  = '0;
              st_d   = ST_GAP;
            end else begin
              shift_en = 1'b1;
            end
          end
        end
      end
      ST_GAP: begin
        gap_d = gap_q + 1'b1;
        if (gap_q == period - 1'b1) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
      bits_q <= '0;
      gap_q  <= '0;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      done_q <= done_d;
      bits_q <= bits_d;
      gap_q  <= gap_d;
    end
  end

  assign run_clk = (st_q == ST_XFER);
  assign sclk    = sclk_q;
  assign cs_n    = cs_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
endmodule

// File: rtl/spi_adc_seq.sv
module spi_adc_seq
  import spi_adc_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] sclk_div,
  input  logic             start,
  input  logic [CH_W-1:0]  chan,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam logic [DIV_W-2:0] MIN_HALF = (DIV_W-1)'(2);

  logic [DIV_W-2:0]   half_eff;
  logic [DIV_W-1:0]   period;
  logic               tick, run_clk, load, shift_en, sample_en, finish;
  logic [FRAME_W-1:0] rx;
  logic [RES_W-1:0]   res_q, res_d;

  assign half_eff = (sclk_div[DIV_W-1:1] < MIN_HALF) ? MIN_HALF : sclk_div[DIV_W-1:1];
  assign period   = {half_eff, 1'b0};

  spi_adc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_clk),
    .half (half_eff),
    .tick (tick)
  );

  spi_adc_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tick     (tick),
    .period   (period),
    .run_clk  (run_clk),
    .load     (load),
    .shift_en (shift_en),
    .sample_en(sample_en),
    .finish   (finish),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .busy     (busy),
    .done     (done)
  );

  spi_adc_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (build_cmd(chan)),
    .shift_en (shift_en),
    .sample_en(sample_en),
    .miso     (miso),
    .mosi     (mosi),
    .rx       (rx)
  );

  always_comb begin
    res_d = res_q;
    if (finish) res_d = rx[RES_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign result = res_q;
endmodule

// File: rtl/spi_adc_seq_chk.sv
module spi_adc_seq_chk
  import spi_adc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result,
  input logic             sclk,
  input logic             mosi,
  input logic             cs_n
);
  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk));
  // R4
  sclk_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);
  // R5
  mosi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  // R5
  mosi_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  // R3
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !$past(cs_n)));
endmodule

bind spi_adc_seq spi_adc_seq_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .done  (done),
  .result(result),
  .sclk  (sclk),
  .mosi  (mosi),
  .cs_n  (cs_n)
);

// File: tb/spi_adc_seq_bench.sv
module spi_adc_seq_bench;
  localparam int DIV_W = 10;

  logic             clk, rst_n, start, busy, done, sclk, mosi, miso, cs_n;
  logic [DIV_W-1:0] sclk_div;
  logic [2:0]       chan;
  logic [11:0]      result;

  int unsigned n_cmp = 0, n_bad = 0;
  bit          finished = 0;

  spi_adc_seq #(.DIV_W(DIV_W)) u_spi_adc_seq (
    .clk(clk), .rst_n(rst_n), .sclk_div(sclk_div), .start(start), .chan(chan),
    .busy(busy), .done(done), .result(result), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // converter model and line monitor, sampled at the falling system edge
  logic [23:0] resp, cap;
  int          idx, cyc, rises, last_rise, period_bad, mosi_bad, done_cnt;
  int          cs_rise_cyc, last_gap;
  logic        p_sclk, p_cs, p_mosi;

  assign miso = (idx >= 0 && idx < 24) ? resp[idx] : 1'b0;

  initial begin
    idx = -1; cyc = 0; rises = 0; last_rise = 0; period_bad = 0; mosi_bad = 0;
    done_cnt = 0; cs_rise_cyc = 0; last_gap = -1; p_sclk = 0; p_cs = 1; p_mosi = 0;
    cap = '0; resp = '0;
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_cs && !cs_n) begin
        idx = 23;
        last_gap = cyc - cs_rise_cyc;
      end
      if (!p_cs && cs_n) cs_rise_cyc = cyc;
      if (!p_sclk && sclk && !cs_n) begin
        cap = {cap[22:0], mosi};
        if (rises > 0 && (cyc - last_rise) != int'(sclk_div)) period_bad++;
        last_rise = cyc;
        rises++;
      end
      if (p_sclk && !sclk && !cs_n) idx--;
      if (sclk && mosi != p_mosi) mosi_bad++;
      if (done) done_cnt++;
    end
    p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
  end

  function automatic logic [23:0] exp_cmd(input logic [2:0] ch);
    return {5'b00000, 1'b1, 1'b1, ch, 14'd0};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic conv(input logic [2:0] ch, input logic [11:0] val,
                      input int div, input bit poke);
    wait_idle();
    sclk_div = DIV_W'(div);
    resp = {12'($urandom), val};
    rises = 0; period_bad = 0; mosi_bad = 0; done_cnt = 0; cap = '0;
    chan = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (div * 3) @(negedge clk);
      chan = ~ch; start = 1'b1;
      @(negedge clk);
      start = 1'b0; chan = ch;
    end
    while (!done) @(negedge clk);
    check(result == val, "R2 result", result, val);
    check(cs_n == 1'b1, "R3 cs at done", cs_n, 1);
    @(negedge clk);
    check(done == 1'b0, "R7 done width", done, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    check(result == val, "R7 result held", result, val);
    check(cap == exp_cmd(poke ? ch : ch), "R1 command frame", cap, exp_cmd(ch));
    check(rises == 24, "R3 rising edges", rises, 24);
    check(period_bad == 0, "R4 sclk period", period_bad, 0);
    check(mosi_bad == 0, "R5 mosi stable while sclk high", mosi_bad, 0);
    if (poke) check(done_cnt == 1, "R6 start while busy ignored", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h00C0FFEE);
    rst_n = 1'b0; start = 1'b0; chan = '0; sclk_div = DIV_W'(4);
    repeat (4) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0,
          "R9 reset state", {cs_n, sclk, busy, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n == 1'b1 && busy == 1'b0, "R9 idle after reset", {cs_n, busy}, 2'b10);

    conv(3'd0, 12'h000, 4, 0);
    conv(3'd7, 12'hFFF, 4, 0);
    conv(3'd5, 12'hA5A, 64, 0);
    conv(3'd4, 12'h800, 8, 0);
    conv(3'd3, 12'h3C1, 8, 1);
    for (int i = 0; i < 12; i++) begin
      int d;
      d = 4 + 2 * int'($urandom_range(0, 6));
      conv(3'($urandom), 12'($urandom), d, bit'($urandom_range(0, 1)));
    end

    // R8: start held high across back-to-back frames
    wait_idle();
    sclk_div = DIV_W'(6);
    chan = 3'd2; start = 1'b1;
    while (!done) @(negedge clk);
    @(negedge clk);
    while (cs_n) @(negedge clk);
    start = 1'b0;
    check(last_gap >= 6, "R8 gap between frames", last_gap, 6);
    check(busy == 1'b1, "R9 busy during frame", busy, 1);
    wait_idle();
    check(cs_n == 1'b1 && sclk == 1'b0, "R9 idle lines", {cs_n, sclk}, 2'b10);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule